// File: doc/BRIEF.md
# Control Endpoint Handshake Response Controller

This block holds the status and control fields of the default control endpoint in a USB device-side controller. It exposes one register on a simple address/strobe bus. The register carries the following fields:

- a read-only data-toggle monitor;
- a control-transfer-end enable;
- a two-bit response selector;
- two write-only commands that force the toggle.

From the response selector and a buffer-ready flag, the block continuously drives the handshake that the packet engine should return for the next token: NAK, ACK or STALL.

The protocol engine reports three kinds of event, and the block updates its own fields in reaction:

- **SETUP token received.** The toggle returns to DATA1, the response drops to NAK and the end enable clears, so software must explicitly re-arm the endpoint for the new transfer.
- **Transfer error.** The block writes STALL into the response selector by itself, which ends the transfer.
- **Accepted data packet.** The toggle flips.

An asynchronous active-low reset is taken in at once and released through a two-stage synchronizer.

Top module: `ctl_ep_resp`

## Requirements
- R1: After reset the register reads 0x0040: toggle monitor 1 (DATA1) at bit 6, end enable 0 at bit 2, response field 00 at bits 1:0. The handshake output is NAK (code 0).
- R2: Bits 5:3 and every bit above bit 6 always read 0. Writing ones to bits 7:3 changes no readable field.
- R3: Handshake output codes are NAK=0, ACK=1 and STALL=2. Response 00 gives NAK. Response 01 gives ACK when buf_ready is 1 and NAK when it is 0. Responses 10 and 11 both give STALL. The output follows the fields and buf_ready without a clock delay.
- R4: A setup_rx pulse makes the next read show toggle 1, end enable 0 and response 00. This holds even when a register write or xfer_err occurs in the same cycle.
- R5: An xfer_err pulse without setup_rx makes the response field read 10 on the next cycle, overriding the response bits of a same-cycle write. The end-enable bit of that write is still taken.
- R6: A data_ack_rx pulse inverts the toggle monitor on the next cycle.
- R7: A write with bit 9 set clears the toggle to 0 (DATA0), and a write with bit 8 set sets it to 1 (DATA1). These commands act only when the response field is 00 before the write. Otherwise they are ignored. Both bits read 0.
- R8: A write with bits 9 and 8 both set leaves the toggle unchanged.
- R9: A write to the register address stores bit 2 into the end enable and bits 1:0 into the response field, visible on the next cycle.
- R10: Writes to any other address change nothing, and reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | AW (4) | Register address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DW (16) | Write data |
| bus_rdata | output | DW (16) | Read data, combinational from bus_addr |
| setup_rx | input | 1 | One-cycle pulse: SETUP token received |
| data_ack_rx | input | 1 | One-cycle pulse: data packet accepted |
| xfer_err | input | 1 | One-cycle pulse: transfer error detected |
| buf_ready | input | 1 | Endpoint buffer can serve the token |
| hs_sel | output | 2 | Handshake to return: 0 NAK, 1 ACK, 2 STALL |

## Verification
Register writes and all three event pulses are captured at one clock edge, and their effect is due on the read port in the cycle after that edge. The bench therefore drives every stimulus just after a falling edge. It removes the stimulus at the next falling edge, which comes after the capturing rising edge, and reads back there.

The handshake output and read data are combinational. The bench samples them one nanosecond after changing bus_addr or buf_ready, inside the same cycle.

Same-cycle collisions are stimulated in a single drive step, so the priority rules are tested on the exact edge where they apply:
- setup against a write and an error;
- an error against a write;
- the two toggle commands against each other.

// File: rtl/ctl_ep_pkg.sv
package ctl_ep_pkg;

  typedef enum logic [1:0] {
    HS_NAK   = 2'd0,
    HS_ACK   = 2'd1,
    HS_STALL = 2'd2
  } hs_e;

  typedef enum logic [1:0] {
    RSP_NAK    = 2'b00,
    RSP_BUF    = 2'b01,
    RSP_STALL  = 2'b10,
    RSP_STALL2 = 2'b11
  } rsp_e;

endpackage

// File: rtl/ep_rst_sync.sv
module ep_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sh_q[STAGES-1];

endmodule

// File: rtl/ep_toggle_mon.sv
module ep_toggle_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic setup_i,
  input  logic data_ok_i,
  input  logic cmd_en_i,
  input  logic cmd_set_i,
  input  logic cmd_clr_i,
  output logic tog_o
);

  logic tog_q;
  logic tog_d;
  logic tog_en;
  logic cmd_hit;

  // exactly one command bit set, and commands allowed
  assign cmd_hit = cmd_en_i & (cmd_set_i ^ cmd_clr_i);

  always_comb begin
    tog_d  = tog_q;
    tog_en = 1'b0;
    if (setup_i) begin
      tog_d  = 1'b1;
      tog_en = 1'b1;
    end else if (cmd_hit) begin
      tog_d  = cmd_set_i;
      tog_en = 1'b1;
    end else if (data_ok_i) begin
      tog_d  = ~tog_q;
      tog_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tog_q <= 1'b1;
    else if (tog_en) tog_q <= tog_d;
  end

  assign tog_o = tog_q;

  AST_SETUP_TOG_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    setup_i |=> tog_o) else $error("setup did not force DATA1"); // R4

  AST_DATA_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ok_i && !setup_i && !cmd_en_i) |=> (tog_o != $past(tog_o)))
    else $error("data accept did not flip toggle"); // R6

  AST_BOTH_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_en_i && cmd_set_i && cmd_clr_i && !setup_i && !data_ok_i) |=> $stable(tog_o))
    else $error("set+clear changed toggle"); // R8

endmodule

// File: rtl/ep_resp_field.sv
module ep_resp_field
  import ctl_ep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       setup_i,
  input  logic       err_i,
  input  logic       wr_i,
  input  logic [1:0] wr_rsp_i,
  input  logic       wr_cend_i,
  output logic [1:0] rsp_o,
  output logic       cend_o
);

  logic [1:0] rsp_q, rsp_d;
  logic       cend_q, cend_d;
  logic       rsp_en, cend_en;

  always_comb begin
    rsp_d   = rsp_q;
    cend_d  = cend_q;
    rsp_en  = 1'b0;
    cend_en = 1'b0;
    if (setup_i) begin
      rsp_d   = RSP_NAK;
      cend_d  = 1'b0;
      rsp_en  = 1'b1;
      cend_en = 1'b1;
    end else begin
      if (err_i) begin
        rsp_d  = RSP_STALL;
        rsp_en = 1'b1;
      end else if (wr_i) begin
        rsp_d  = wr_rsp_i;
        rsp_en = 1'b1;
      end
      if (wr_i) begin
        cend_d  = wr_cend_i;
        cend_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rsp_q <= RSP_NAK;
    else if (rsp_en) rsp_q <= rsp_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cend_q <= 1'b0;
    else if (cend_en) cend_q <= cend_d;
  end

  assign rsp_o  = rsp_q;
  assign cend_o = cend_q;

  AST_SETUP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    setup_i |=> (rsp_o == RSP_NAK && !cend_o)) else $error("setup did not clear fields"); // R4

  AST_ERR_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (err_i && !setup_i) |=> (rsp_o == RSP_STALL)) else $error("error did not stall"); // R5

endmodule

// File: rtl/ep_hs_decode.sv
module ep_hs_decode
  import ctl_ep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rsp_i,
  input  logic       buf_rdy_i,
  output logic [1:0] hs_o
);

  always_comb begin
    unique case (rsp_i)
      RSP_NAK:    hs_o = HS_NAK;
      RSP_BUF:    hs_o = buf_rdy_i ? HS_ACK : HS_NAK;
      default:    hs_o = HS_STALL;
    endcase
  end

  AST_STALL_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_i[1] |-> (hs_o == HS_STALL)) else $error("upper code not STALL"); // R3

  AST_NO_ACK_UNREADY: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_rdy_i |-> (hs_o != HS_ACK)) else $error("ACK without buffer"); // R3

endmodule

// File: rtl/ctl_ep_resp.sv
module ctl_ep_resp
  import ctl_ep_pkg::*;
#(
  parameter int          AW       = 4,
  parameter int          DW       = 16,
  parameter logic [AW-1:0] REG_ADDR = '0,
  parameter int          RST_STG  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          setup_rx,
  input  logic          data_ack_rx,
  input  logic          xfer_err,
  input  logic          buf_ready,
  output logic [1:0]    hs_sel
);

  localparam int RSP_LSB  = 0;
  localparam int CEND_BIT = 2;
  localparam int TOG_BIT  = 6;
  localparam int SET_BIT  = 8;
  localparam int CLR_BIT  = 9;

  logic       rst_sn;
  logic       sel;
  logic       wr;
  logic       cmd_en;
  logic       tog;
  logic       cend;
  logic [1:0] rsp;
  logic       unused_wdata;

  ep_rst_sync #(.STAGES(RST_STG)) i_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sn)
  );

  assign sel    = (bus_addr == REG_ADDR);
  assign wr     = bus_we & sel;
  assign cmd_en = wr & (rsp == RSP_NAK);
  assign unused_wdata = ^bus_wdata;

  ep_toggle_mon i_tog (
    .clk       (clk),
    .rst_n     (rst_sn),
    .setup_i   (setup_rx),
    .data_ok_i (data_ack_rx),
    .cmd_en_i  (cmd_en),
    .cmd_set_i (bus_wdata[SET_BIT]),
    .cmd_clr_i (bus_wdata[CLR_BIT]),
    .tog_o     (tog)
  );

  ep_resp_field i_rsp (
    .clk       (clk),
    .rst_n     (rst_sn),
    .setup_i   (setup_rx),
    .err_i     (xfer_err),
    .wr_i      (wr),
    .wr_rsp_i  (bus_wdata[RSP_LSB+1:RSP_LSB]),
    .wr_cend_i (bus_wdata[CEND_BIT]),
    .rsp_o     (rsp),
    .cend_o    (cend)
  );

  ep_hs_decode i_hs (
    .clk       (clk),
    .rst_n     (rst_sn),
    .rsp_i     (rsp),
    .buf_rdy_i (buf_ready),
    .hs_o      (hs_sel)
  );

  always_comb begin
    bus_rdata = '0;
    if (sel) begin
      bus_rdata[TOG_BIT]             = tog;
      bus_rdata[CEND_BIT]            = cend;
      bus_rdata[RSP_LSB+1:RSP_LSB]   = rsp;
    end
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_rdata[5:3] == 3'b000) && (bus_rdata[DW-1:7] == '0)) else $error("reserved bits set"); // R2

  AST_OTHER_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_sn)
    !sel |-> (bus_rdata == '0)) else $error("unmapped read nonzero"); // R10

  AST_CMD_GATED: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr && rsp != RSP_NAK && !setup_rx && !data_ack_rx) |=> $stable(tog))
    else $error("toggle command acted outside NAK"); // R7

endmodule

// File: tb/test_ctl_ep_resp.sv
module test_ctl_ep_resp;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic        bus_we;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        setup_rx, data_ack_rx, xfer_err, buf_ready;
  logic [1:0]  hs_sel;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  ctl_ep_resp i_ctl_ep_resp (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .setup_rx(setup_rx),
    .data_ack_rx(data_ack_rx), .xfer_err(xfer_err), .buf_ready(buf_ready),
    .hs_sel(hs_sel)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  // drive one cycle of stimulus; state is updated when this returns
  task automatic step(input logic we, input logic [3:0] a, input logic [15:0] d,
                      input logic su, input logic dk, input logic er);
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d;
    setup_rx = su; data_ack_rx = dk; xfer_err = er;
    @(negedge clk);
    bus_we = 1'b0; setup_rx = 1'b0; data_ack_rx = 1'b0; xfer_err = 1'b0;
    bus_addr = 4'd0;
  endtask

  task automatic wr(input logic [15:0] d);
    step(1'b1, 4'd0, d, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(4'd0, v);
    check("R1 reset value", v, 16'h0040);
    buf_ready = 1'b1; #1;
    check("R1 reset handshake", {14'd0, hs_sel}, 16'd0);
    buf_ready = 1'b0;
  endtask

  task automatic t_rw;
    logic [15:0] v;
    wr(16'h0005);
    rd(4'd0, v);
    check("R9 write fields", v, 16'h0045);
    wr(16'h00F8);
    rd(4'd0, v);
    check("R2 reserved bits ignored", v, 16'h0040);
  endtask

  task automatic t_hs;
    wr(16'h0001);
    buf_ready = 1'b1; #1;
    check("R3 BUF ready -> ACK", {14'd0, hs_sel}, 16'd1);
    buf_ready = 1'b0; #1;
    check("R3 BUF not ready -> NAK", {14'd0, hs_sel}, 16'd0);
    wr(16'h0002);
    buf_ready = 1'b1; #1;
    check("R3 code 10 -> STALL", {14'd0, hs_sel}, 16'd2);
    wr(16'h0003); #1;
    check("R3 code 11 -> STALL", {14'd0, hs_sel}, 16'd2);
    wr(16'h0000); #1;
    check("R3 code 00 -> NAK", {14'd0, hs_sel}, 16'd0);
    buf_ready = 1'b0;
  endtask

  task automatic t_toggle;
    logic [15:0] v;
    wr(16'h0200);
    rd(4'd0, v); check("R7 clear command", v, 16'h0000);
    step(1'b0, 4'd0, 16'h0, 1'b0, 1'b1, 1'b0);
    rd(4'd0, v); check("R6 data accept flips to 1", v, 16'h0040);
    step(1'b0, 4'd0, 16'h0, 1'b0, 1'b1, 1'b0);
    rd(4'd0, v); check("R6 data accept flips to 0", v, 16'h0000);
    wr(16'h0100);
    rd(4'd0, v); check("R7 set command", v, 16'h0040);
    wr(16'h0200);
    wr(16'h0300);
    rd(4'd0, v); check("R8 both commands ignored", v, 16'h0000);
    wr(16'h0001);
    wr(16'h0101);
    rd(4'd0, v); check("R7 set ignored outside NAK", v, 16'h0001);
  endtask

  task automatic t_setup;
    logic [15:0] v;
    wr(16'h0006);
    step(1'b1, 4'd0, 16'h0005, 1'b1, 1'b0, 1'b1);
    rd(4'd0, v); check("R4 setup wins over write and error", v, 16'h0040);
  endtask

  task automatic t_err;
    logic [15:0] v;
    wr(16'h0001);
    step(1'b1, 4'd0, 16'h0005, 1'b0, 1'b0, 1'b1);
    rd(4'd0, v); check("R5 error forces STALL, keeps end bit", v, 16'h0046);
    buf_ready = 1'b1; #1;
    check("R5 handshake after error", {14'd0, hs_sel}, 16'd2);
    buf_ready = 1'b0;
  endtask

  task automatic t_addr;
    logic [15:0] v;
    wr(16'h0000);
    step(1'b1, 4'd1, 16'h0307, 1'b0, 1'b0, 1'b0);
    rd(4'd1, v); check("R10 other address reads 0", v, 16'h0000);
    rd(4'd0, v); check("R10 other address write ignored", v, 16'h0040);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    setup_rx = 1'b0; data_ack_rx = 1'b0; xfer_err = 1'b0; buf_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_rw();
    t_hs();
    t_toggle();
    t_setup();
    t_err();
    t_addr();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule